// File: doc/BRIEF.md
# Write-Only Two-Wire Output-Enable Configuration Slave

This block is the configuration port of a multi-output clock driver. It watches a two-wire serial bus (a clock line and an open-drain data line), both sampled by the local system clock through two-stage synchronisers. It recognises start and stop conditions, shifts in bytes with the most significant bit first, and pulls the data line low during the ninth clock of every byte that belongs to a transaction addressed to it.

A transaction is a block write with fixed byte positions. The first byte is the device address, and it must equal 8'hD2 exactly, read/write bit included. The next two bytes are a command code and a byte count. Both are acknowledged and then discarded. The three bytes after those carry enable bits for thirteen clock outputs. Each register is loaded as soon as its byte is complete. Any bytes after the third data byte are acknowledged and have no effect. The block never drives data back onto the bus.

Top module: `clkcfg_serial_slave`

## Requirements
- R1: After a synchronous reset, all thirteen enables in `out_en_o` are 1 and `sda_pull_o` is 0.
- R2: If the first byte after a start is anything other than 8'hD2 (for example 8'hD3 or 8'h52), the slave gives no acknowledge (the data line stays high on the ninth clock) and the enables do not change until the next start.
- R3: The second byte (command code) and the third byte (byte count) are each acknowledged, whatever their values, and neither changes the enables.
- R4: Bytes arrive most significant bit first. The first data bit on the bus is bit 7.
- R5: The acknowledge is a pull-down on `sda_pull_o`. It is applied while the clock is low after the eighth bit, so the data line is low through the ninth clock. It is released after the ninth clock falls.
- R6: Data byte 0 (the fourth byte) sets the enables as follows: output 5 from bit 7, output 4 from bit 6, and outputs 3..0 from bits 3..0. Bits 5 and 4 have no effect.
- R7: Data byte 1 (the fifth byte) sets outputs 11..8 from bits 7..4 and outputs 7..6 from bits 1..0. Bits 3 and 2 have no effect.
- R8: Data byte 2 (the sixth byte) sets output 12 from bit 6. All its other bits have no effect. A 1 enables an output and a 0 disables it.
- R9: From the seventh byte on, each byte is acknowledged and changes nothing.
- R10: The enables for a data byte change once its eighth bit has been received, before any stop condition. They change at no other time.
- R11: A stop or start condition in the middle of a byte abandons that byte, and its content is never applied. A start always begins a new transaction at the address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line (asynchronous) |
| sda_i | input | 1 | Serial data line as seen on the bus (asynchronous) |
| sda_pull_o | output | 1 | 1 pulls the data line low (acknowledge) |
| out_en_o | output | 13 | Enable vector, one bit per clock output |

## Verification
The assertions assume that both bus lines stay at each level for several system clocks longer than the synchroniser depth. They also assume the data line changes only while the clock is low, except when a start or stop condition is intended. Under these assumptions, a clock edge and a data edge never reach the detector in the same cycle. The stimulus holds every clock phase for eight system clocks. It moves the data line only in the middle of a low phase, and moves it while the clock is high only to form a start or stop. The bench also models the wired-AND bus, combining the master's drive with the slave's pull-down.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int NUM_OUT        = 13;
  localparam int IDX_W          = 4;
  localparam int FIRST_DATA_IDX = 3;
  localparam int NUM_DATA_REGS  = 3;
  localparam logic [7:0] DEF_DEV_ADDR = 8'hD2;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_BITS = 2'd1,
    RX_ACK  = 2'd2,
    RX_SKIP = 2'd3
  } rx_state_t;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  // data edge while the clock is (and was) high
  assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/twi_byte_rx.sv
module twi_byte_rx
  import clkcfg_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR = DEF_DEV_ADDR
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_lvl,
  input  logic             sda_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  output logic             sda_pull,
  output logic             wr_valid,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  rx_state_t        state;
  logic [7:0]       shreg;
  logic [2:0]       bit_cnt;
  logic             byte_full;
  logic [IDX_W-1:0] byte_idx;
  logic [7:0]       next_byte;

  assign next_byte = {shreg[6:0], sda_lvl};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_IDLE;
      shreg     <= '0;
      bit_cnt   <= '0;
      byte_full <= 1'b0;
      byte_idx  <= '0;
      sda_pull  <= 1'b0;
      wr_valid  <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (start_det) begin
        state     <= RX_BITS;
        bit_cnt   <= '0;
        byte_full <= 1'b0;
        byte_idx  <= '0;
        sda_pull  <= 1'b0;
      end else if (stop_det) begin
        state     <= RX_IDLE;
        byte_full <= 1'b0;
        sda_pull  <= 1'b0;
      end else begin
        unique case (state)
          RX_BITS: begin
            if (scl_rise && !byte_full) begin
              shreg   <= next_byte;
              bit_cnt <= bit_cnt + 3'd1;
              if (bit_cnt == 3'd7) begin
                byte_full <= 1'b1;
                if (byte_idx >= IDX_W'(FIRST_DATA_IDX)) begin
                  wr_valid <= 1'b1;
                  wr_idx   <= byte_idx;
                  wr_data  <= next_byte;
                end
              end
            end else if (scl_fall && byte_full) begin
              byte_full <= 1'b0;
              if (byte_idx == '0 && shreg != DEV_ADDR) begin
                state <= RX_SKIP;
              end else begin
                state    <= RX_ACK;
                sda_pull <= 1'b1;
              end
            end
          end
          RX_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              state    <= RX_BITS;
              bit_cnt  <= '0;
              if (byte_idx != IDX_MAX) byte_idx <= byte_idx + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R5: the pull-down is only applied while the clock line is low
  p_ack_low_phase_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> !scl_lvl);
  // R5: release of the pull-down follows a clock fall or a bus condition
  p_ack_release_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_pull) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));
  // R2: an unaddressed transaction never drives the line
  p_no_pull_skip_r2: assert property (@(posedge clk) disable iff (rst)
    (state == RX_SKIP || state == RX_IDLE) |-> !sda_pull);
  // R11: a stop returns to idle
  p_stop_idle_r11: assert property (@(posedge clk) disable iff (rst)
    stop_det && !start_det |=> (state == RX_IDLE && !sda_pull));
endmodule

// File: rtl/out_en_bank.sv
module out_en_bank
  import clkcfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_valid,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [7:0]         wr_data,
  output logic [NUM_OUT-1:0] out_en
);
  // per-register: which enable bits a data byte owns and where they come from
  logic [NUM_OUT-1:0] own_mask [NUM_DATA_REGS];
  logic [NUM_OUT-1:0] own_val  [NUM_DATA_REGS];
  logic [NUM_OUT-1:0] nxt_en;

  always_comb begin
    own_mask[0] = 13'h003F;
    own_val[0]  = {7'b0, wr_data[7], wr_data[6], wr_data[3:0]};
    own_mask[1] = 13'h0FC0;
    own_val[1]  = {1'b0, wr_data[7:4], wr_data[1:0], 6'b0};
    own_mask[2] = 13'h1000;
    own_val[2]  = {wr_data[6], 12'b0};
  end

  always_comb begin
    nxt_en = out_en;
    for (int r = 0; r < NUM_DATA_REGS; r++) begin
      if (wr_valid && wr_idx == IDX_W'(FIRST_DATA_IDX + r))
        nxt_en = (out_en & ~own_mask[r]) | (own_val[r] & own_mask[r]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_en <= '1;
    else     out_en <= nxt_en;
  end

  // R1: reset enables every output
  p_reset_all_on_r1: assert property (@(posedge clk)
    rst |=> (out_en == '1));
  // R10: enables move only on a completed data byte
  p_hold_between_bytes_r10: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |=> $stable(out_en));
  // R8: data byte 2 touches nothing but output 12
  p_byte2_only_top_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_idx == IDX_W'(FIRST_DATA_IDX + 2)) |=> $stable(out_en[11:0]));
  // R9: bytes after the third data byte change nothing
  p_late_bytes_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_idx > IDX_W'(FIRST_DATA_IDX + 2)) |=> $stable(out_en));
endmodule

// File: rtl/clkcfg_serial_slave.sv
module clkcfg_serial_slave
  import clkcfg_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] DEV_ADDR    = DEF_DEV_ADDR
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  output logic [NUM_OUT-1:0] out_en_o
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic             wr_valid;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  twi_byte_rx #(.DEV_ADDR(DEV_ADDR)) u_rx (
    .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .sda_pull(sda_pull_o), .wr_valid(wr_valid),
    .wr_idx(wr_idx), .wr_data(wr_data)
  );

  out_en_bank u_bank (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_idx(wr_idx),
    .wr_data(wr_data), .out_en(out_en_o)
  );
endmodule

// File: tb/clkcfg_serial_slave_bench.sv
`timescale 1ns/1ps
module clkcfg_serial_slave_bench;
  localparam int Q = 8;  // system clocks per bus clock phase

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull;
  logic [12:0] out_en;
  wire  sda_bus = sda_m & ~sda_pull;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  logic exp_q[$];        // expected bus level on each ninth clock
  int   bitpos = 0;
  logic [12:0] model = 13'h1FFF;

  always #10 clk = ~clk;

  clkcfg_serial_slave u_clkcfg_serial_slave (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .out_en_o(out_en)
  );

  // monitor: frames bytes from the bus and compares each ninth-clock level
  always @(negedge sda_bus) if (scl_m) bitpos = 0;
  always @(posedge scl_m) begin
    #1;
    bitpos++;
    if (bitpos == 9) begin
      bitpos = 0;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R5 unexpected ninth clock: actual=%b expected=none", sda_bus);
      end else begin
        logic e;
        e = exp_q.pop_front();
        if (sda_bus !== e) begin
          errors++;
          $display("FAIL R2/R3/R5/R9 ack level: actual=%b expected=%b", sda_bus, e);
        end
      end
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_en(logic [12:0] exp, string req);
    checks++;
    if (out_en !== exp) begin
      errors++;
      $display("FAIL %s out_en: actual=%h expected=%h", req, out_en, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(Q/2); scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b0; wait_clk(Q); scl_m = 1'b0; wait_clk(Q/2);
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; wait_clk(Q/2); sda_m = 1'b0; wait_clk(Q/2);
    scl_m = 1'b1; wait_clk(Q); sda_m = 1'b1; wait_clk(Q);
  endtask

  task automatic clk_bit(logic b);
    wait_clk(Q/2); sda_m = b; wait_clk(Q/2);
    scl_m = 1'b1; wait_clk(Q); scl_m = 1'b0;
  endtask

  // driver: shifts a byte MSB first (R4) and queues the expected ack level
  task automatic send_byte(logic [7:0] b, logic ack_level);
    for (int i = 7; i >= 0; i--) clk_bit(b[i]);
    exp_q.push_back(ack_level);
    clk_bit(1'b1);
    wait_clk(Q/2);
  endtask

  // expected enables from the byte maps of R6..R8
  function automatic logic [12:0] apply(int dnum, logic [7:0] b, logic [12:0] cur);
    logic [12:0] n = cur;
    case (dnum)
      0: begin n[5] = b[7]; n[4] = b[6]; n[3:0] = b[3:0]; end
      1: begin n[11:8] = b[7:4]; n[7:6] = b[1:0]; end
      2: n[12] = b[6];
      default: ;
    endcase
    return n;
  endfunction

  task automatic write_cfg(logic [7:0] cmd, logic [7:0] cnt, logic [7:0] d[], bit check_each);
    bus_start();
    send_byte(8'hD2, 1'b0);
    send_byte(cmd, 1'b0);                     // R3
    check_en(model, "R3 after command byte");
    send_byte(cnt, 1'b0);                     // R3
    check_en(model, "R3 after count byte");
    foreach (d[k]) begin
      send_byte(d[k], 1'b0);
      model = apply(k, d[k], model);
      if (check_each) check_en(model, "R10 before stop");
    end
    bus_stop();
  endtask

  initial begin
    wait_clk(150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_clk(4); rst = 1'b0; wait_clk(4);
    check_en(13'h1FFF, "R1 reset enables");
    checks++;
    if (sda_pull !== 1'b0) begin
      errors++; $display("FAIL R1 sda_pull: actual=%b expected=0", sda_pull);
    end

    // R6/R7/R8 all cleared, checked byte by byte (R10)
    write_cfg(8'hA5, 8'h55, '{8'h00, 8'h00, 8'h00}, 1'b1);
    check_en(13'h0000, "R6 R7 R8 clear all");

    // R6 reserved bits 5,4 alone set nothing
    write_cfg(8'h00, 8'h00, '{8'h30}, 1'b1);
    check_en(13'h0000, "R6 reserved bits");

    // R4 MSB first: 0x01 sets output 0, 0x80 sets output 5
    write_cfg(8'h00, 8'h01, '{8'h01}, 1'b0);
    check_en(13'h0001, "R4 lsb to output0");
    write_cfg(8'h00, 8'h01, '{8'h80}, 1'b0);
    check_en(13'h0020, "R4 msb to output5");

    // R6/R7/R8 mixed pattern, then late bytes (R9)
    write_cfg(8'hD2, 8'hFF, '{8'h8F, 8'h53, 8'hBF, 8'hFF, 8'hFF, 8'hFF, 8'hFF}, 1'b1);
    check_en(13'h05EF, "R7 R8 R9 mixed pattern");

    // R8 output 12 from bit 6 only
    write_cfg(8'h12, 8'h34, '{8'h8F, 8'h53, 8'h40}, 1'b0);
    check_en(13'h15EF, "R8 bit6 enables output12");

    // R2 wrong addresses: no ack, no change
    bus_start(); send_byte(8'hD3, 1'b1); send_byte(8'h00, 1'b1); bus_stop();
    check_en(13'h15EF, "R2 read-bit address");
    bus_start(); send_byte(8'h52, 1'b1); bus_stop();
    check_en(13'h15EF, "R2 other address");

    // R11 stop in the middle of data byte 0
    bus_start(); send_byte(8'hD2, 1'b0); send_byte(8'h00, 1'b0); send_byte(8'h00, 1'b0);
    for (int i = 0; i < 4; i++) clk_bit(1'b0);
    bus_stop();
    check_en(13'h15EF, "R11 stop mid byte");

    // R11 repeated start mid address byte, new transaction proceeds
    bus_start();
    for (int i = 0; i < 3; i++) clk_bit(1'b1);
    wait_clk(Q/2); sda_m = 1'b1; wait_clk(Q/2);
    scl_m = 1'b1; wait_clk(Q); sda_m = 1'b0; wait_clk(Q); scl_m = 1'b0; wait_clk(Q/2);
    send_byte(8'hD2, 1'b0); send_byte(8'h00, 1'b0); send_byte(8'h00, 1'b0);
    send_byte(8'hFF, 1'b0);
    model = apply(0, 8'hFF, model);
    check_en(model, "R11 restart then data byte0");
    bus_stop();
    check_en(13'h15FF, "R11 final value");

    wait_clk(Q);
    checks++;
    if (exp_q.size() != 0) begin
      errors++; $display("FAIL R5 pending acks: actual=%0d expected=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule